// File: doc/BRIEF.md
# Serial-In Odd-Parity Word Framer

This block turns a one-bit serial stream into a stream of parallel words. It takes one bit from the serial input on every clock and groups each run of seven consecutive bits into a word. Each word leaves the block as eight parallel bits: the seven data bits and an odd-parity bit. A one-clock valid strobe marks the cycle in which a new word appears.

Framing never pauses. The cycle in which a finished word is shown is also the cycle in which the first bit of the next word is taken. As a result, a new word arrives every seven clocks with no idle gap.

Parity builds up serially as the bits arrive. The accumulator is seeded so that, once the seventh bit is in, it already holds the odd-parity value. The reset input is active low. It asserts asynchronously and is released through an internal two-stage synchronizer. After release, the first bit sampled starts a fresh word.

Top module: `serial_parity_framer`

## Requirements
- R1: One bit is sampled from `ser_i` on every clock once reset has been released, and seven consecutive samples form one word. The first bit received appears on `word_o[7]` and the seventh on `word_o[1]`.
- R2: `word_o[0]` is the parity bit, chosen so that the number of ones in `word_o[7:0]` is odd whenever a word is presented.
- R3: `word_vld_o` is high for exactly one clock per word. That clock is the one following the clock edge that samples the seventh bit. `word_vld_o` is low in all other cycles.
- R4: The bit sampled at the end of a strobe cycle is the first bit of the next word. Strobes therefore repeat every seven clocks with no gap.
- R5: `word_o` keeps its value in every cycle that is not a strobe cycle.
- R6: While `rst_n` is low, `word_o` is all zero and `word_vld_o` is low, and both take these values as soon as `rst_n` falls, without waiting for a clock. Serial input received during reset has no effect on the outputs.
- R7: Feeding the words 0101010, 1011100, 0000000 and 1111111 back to back (first bit leftmost) gives the parity bits 0, 1, 1 and 0 in that order.
- R8: A reset in the middle of a word discards the partial word, so no strobe is produced for it. Framing then restarts cleanly: after `rst_n` rises, the block waits for two clock edges, and the bit sampled at the third edge is the first bit of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| ser_i | input | 1 | Serial data, one bit per clock |
| word_o | output | 8 | Presented word: `[7:1]` data (first bit in bit 7), `[0]` odd parity |
| word_vld_o | output | 1 | One-clock strobe marking a newly presented word |

## Verification
Some behaviours are checked by the embedded assertions on every cycle:
- that each presented word has odd weight;
- that the strobe never lasts longer than one clock;
- that the output holds between strobes;
- that strobes are exactly seven clocks apart;
- that the position counter stays in range.

Other behaviours can only be shown by the bench's scenarios, because they need known stimulus:
- bit ordering within a word;
- the specific parity values for the four reference words;
- the fact that the strobe-cycle bit opens the next word;
- how reset in mid-word and the release latency re-align framing.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Default data bits per word
  parameter int unsigned WORD_BITS = 7;
  // Default reset release synchronizer depth
  parameter int unsigned SYNC_DEPTH = 2;

  // Seed of the parity accumulator: 1 gives odd parity
  localparam logic ODD_SEED = 1'b1;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync #(
  parameter int unsigned DEPTH = sp_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[DEPTH-1];
endmodule

// File: rtl/sp_pos_counter.sv
module sp_pos_counter #(
  parameter int unsigned W = sp_pkg::WORD_BITS
) (
  input  logic clk,
  input  logic rst_n,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_d;

  always_comb begin
    if (pos_q == LAST) pos_d = '0;
    else               pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign first_o = (pos_q == '0);
  assign last_o  = (pos_q == LAST);

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);

  // R4
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> first_o);
endmodule

// File: rtl/sp_par_shift.sv
module sp_par_shift #(
  parameter int unsigned W = sp_pkg::WORD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  input  logic         first_i,
  output logic [W-1:0] word_o,
  output logic         par_o
);
  // Holds the bits before the current one; the current bit is appended combinationally
  logic [W-2:0] sh_q, sh_d;
  logic         acc_q, acc_d;

  always_comb begin
    if (first_i) begin
      sh_d  = {{(W-2){1'b0}}, bit_i};
      acc_d = sp_pkg::ODD_SEED ^ bit_i;
    end else begin
      sh_d  = {sh_q[W-3:0], bit_i};
      acc_d = acc_q ^ bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      acc_q <= sp_pkg::ODD_SEED;
    end else begin
      sh_q  <= sh_d;
      acc_q <= acc_d;
    end
  end

  assign word_o = {sh_q, bit_i};
  assign par_o  = acc_q ^ bit_i;
endmodule

// File: rtl/sp_out_reg.sv
module sp_out_reg #(
  parameter int unsigned W = sp_pkg::WORD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         par_i,
  output logic [W:0]   data_o,
  output logic         vld_o
);
  logic [W:0] data_d;

  always_comb begin
    data_d = data_o;
    if (load_i) data_d = {word_i, par_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      data_o <= data_d;
      vld_o  <= load_i;
    end
  end

  // R2
  odd_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (^data_o) == 1'b1);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);

  // R5
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> $stable(data_o));
endmodule

// File: rtl/serial_parity_framer.sv
module serial_parity_framer #(
  parameter int unsigned W           = sp_pkg::WORD_BITS,
  parameter int unsigned SYNC_STAGES = sp_pkg::SYNC_DEPTH
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_i,
  output logic [W:0] word_o,
  output logic       word_vld_o
);
  localparam int unsigned GW = $clog2(W + 1);

  logic         rst_int_n;
  logic         first;
  logic         last;
  logic [W-1:0] cur_word;
  logic         cur_par;

  sp_rst_sync #(.DEPTH(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  sp_pos_counter #(.W(W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .first_o (first),
    .last_o  (last)
  );

  sp_par_shift #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_i   (ser_i),
    .first_i (first),
    .word_o  (cur_word),
    .par_o   (cur_par)
  );

  // The output register resets from the raw input so that reset clears the outputs at once
  sp_out_reg #(.W(W)) u_out (
    .clk    (clk),
    .rst_n  (rst_int_n & rst_n),
    .load_i (last),
    .word_i (cur_word),
    .par_i  (cur_par),
    .data_o (word_o),
    .vld_o  (word_vld_o)
  );

  // Checker state: clocks elapsed since the previous strobe
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_vld_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GW'(W)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R4
  word_period_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (word_vld_o && seen_q) |-> gap_q == GW'(W - 1));

  // R4
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    seen_q |-> gap_q < GW'(W));
endmodule

// File: tb/sim_serial_parity_framer.sv
module sim_serial_parity_framer;
  localparam int W  = 7;
  localparam int NV = 8;
  localparam int WD = 20000;

  // {stimulus word (first bit leftmost), expected word_o}
  localparam logic [14:0] TAB [NV] = '{
    {7'b0101010, 8'b01010100},
    {7'b1011100, 8'b10111001},
    {7'b0000000, 8'b00000001},
    {7'b1111111, 8'b11111110},
    {7'b1000000, 8'b10000000},
    {7'b0000001, 8'b00000010},
    {7'b1010101, 8'b10101011},
    {7'b0110011, 8'b01100111}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser;
  logic [W:0] wout;
  logic       vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  serial_parity_framer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_i      (ser),
    .word_o     (wout),
    .word_vld_o (vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  held;
    logic [6:0]  w8;

    rst_n = 1'b0;
    ser   = 1'b1;
    held  = 8'h00;
    repeat (3) @(negedge clk);
    chk("R6 reset word", 32'(wout), 32'h0);
    chk("R6 reset strobe", 32'(vld), 32'h0);

    // Release reset; two edges pass before the first sample
    rst_n = 1'b1;
    ser   = 1'b0;
    @(posedge clk);
    @(posedge clk);

    // Table walk: words back to back
    for (int i = 0; i < NV; i++) begin
      for (int b = W - 1; b >= 0; b--) begin
        @(negedge clk);
        if (b == W - 1 && i > 0) begin
          held = TAB[i-1][7:0];
          chk("R3/R4 strobe on word boundary", 32'(vld), 32'h1);
          chk("R1/R7 presented word", 32'(wout), 32'(held));
          chk("R2 odd weight", 32'(^wout), 32'h1);
        end else begin
          chk("R3 no strobe mid-word", 32'(vld), 32'h0);
          chk("R5 output held", 32'(wout), 32'(held));
        end
        ser = TAB[i][8 + b];
      end
    end
    @(negedge clk);
    held = TAB[NV-1][7:0];
    chk("R3 strobe for last word", 32'(vld), 32'h1);
    chk("R7 last word", 32'(wout), 32'(held));
    ser = 1'b1;
    @(negedge clk);
    chk("R3 strobe drops", 32'(vld), 32'h0);
    chk("R5 hold after strobe", 32'(wout), 32'(held));
    ser = 1'b1;

    // Partial word then reset in mid-word
    @(negedge clk);
    ser = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    chk("R6 async clear word", 32'(wout), 32'h0);
    chk("R6 async clear strobe", 32'(vld), 32'h0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      ser = k[0];
      chk("R6 input ignored in reset", 32'(wout), 32'h0);
      chk("R8 no strobe for discarded word", 32'(vld), 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    ser   = 1'b1;
    @(posedge clk);
    @(posedge clk);

    w8 = 7'b1100101;
    for (int b = W - 1; b >= 0; b--) begin
      @(negedge clk);
      chk("R8 no strobe before seventh bit", 32'(vld), 32'h0);
      ser = w8[b];
    end
    @(negedge clk);
    chk("R8 strobe after restart", 32'(vld), 32'h1);
    chk("R8 restarted word", 32'(wout), 32'h000000CB);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule